// File: doc/BRIEF.md
# PSK Transmit Frame Formatter

This block assembles a phase-shift-keyed transmit frame and turns it into a stream of symbol indices for a downstream phase mapper. A host starts a frame with a one-cycle request. The request carries three things: a preamble byte count, a modulation selection and a payload length. The host then supplies the payload bytes through a byte-wide valid/ready port. The block sends the frame in this order: the preamble bytes, a 32-bit sync word, one mode byte, and then the payload.

The header (preamble, sync word and mode byte) always goes out at one bit per symbol. Any receiver can therefore parse it before it knows the modulation. Only the payload is packed at the selected density: 1, 2 or 3 bits per symbol. Symbols leave at a fixed rate set by a clock-enable divider, with one strobe per symbol.

The first payload byte is requested while the header is still being sent. If the host is late with a byte, the symbol slot that needed it is skipped. The next symbol then waits for a later slot on the same rate grid.

Top module: `psk_frame_tx`

## Requirements
- R1: While reset is held and right after it, `busy`, `sym_stb` and `in_ready` are all 0.
- R2: Each header symbol carries one bit, so `sym` is 0 or 1. Bits go out MSB first, in this order: each preamble byte 0xAA, then the 32-bit sync word `UW` (default 0x9B58A3CD), then the mode byte.
- R3: `pre_len` sets the number of preamble bytes from 2 to 5. A value below 2 sends 2 bytes and a value above 5 sends 5 bytes.
- R4: The mode byte holds 0 for one bit per payload symbol, 1 for two bits and 2 for three bits. The `mode` input uses the same codes, and a code of 3 is treated as 0 for both the mode byte and the packing.
- R5: Payload bits are taken MSB first from each byte and packed into symbols of N = mode+1 bits. The earliest bit sits in `sym[N-1]`, and the bits of `sym` at position N and above are 0. A symbol may span two bytes.
- R6: With three bits per symbol, when the payload bit count is not a multiple of 3, the last symbol is filled with zero bits in its low positions.
- R7: `len_m1` gives the payload length minus one, so lengths run from 1 to 256 bytes. A byte is taken in each cycle where both `in_valid` and `in_ready` are 1, and exactly that many bytes are taken per frame.
- R8: `sym_stb` is a one-cycle pulse. The first pulse comes DIV = CLK_HZ/SYM_HZ cycles after the cycle in which the start was accepted. Later pulses come every DIV cycles while data is available.
- R9: If the next payload symbol lacks bits at a slot because no byte has arrived, that slot produces no strobe. Emission resumes at a later slot, so strobe spacing stays a multiple of DIV, and the symbol values are unchanged.
- R10: `busy` rises in the cycle after the start is accepted. It goes low in the same cycle that the final strobe is high.
- R11: A start request made while `busy` is 1 is ignored. It neither changes the running frame nor queues a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle frame request, taken only when idle |
| pre_len | input | 3 | Preamble byte count (clamped to 2..5) |
| mode | input | 2 | Payload bits per symbol minus one (3 treated as 0) |
| len_m1 | input | 8 | Payload length in bytes minus one |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block can take a payload byte |
| sym_stb | output | 1 | Symbol strobe, one cycle per symbol |
| sym | output | 3 | Symbol index for the phase mapper |
| busy | output | 1 | Frame in progress |

## Verification
Two things can happen in the same cycle: a payload byte can be accepted while a header symbol is being emitted, because the first byte is fetched early. The bench holds `in_valid` high from the start request, so that byte lands during the header. It then checks that the header bits are intact and that the payload symbols keep exact DIV spacing with no gap at the header-to-payload boundary. A second overlap is a start request that arrives in the middle of a frame. That frame must come out unchanged, and no new frame may follow it.

// File: rtl/psk_frame_tx.sv
module psk_frame_tx #(
  parameter int          CLK_HZ = 96000,
  parameter int          SYM_HZ = 9600,
  parameter logic [31:0] UW     = 32'h9B58A3CD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] pre_len,
  input  logic [1:0] mode,
  input  logic [7:0] len_m1,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       sym_stb,
  output logic [2:0] sym,
  output logic       busy
);
  localparam int DIV  = CLK_HZ / SYM_HZ;
  localparam int DIVW = $clog2(DIV + 1);
  localparam logic [DIVW-1:0] DLAST = DIVW'(DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} st_t;

  st_t             phase;
  logic [DIVW-1:0] div_cnt;
  logic [79:0]     hdr_sr;
  logic [6:0]      hdr_left;
  logic [1:0]      bps;
  logic [8:0]      left;
  logic [10:0]     acc;
  logic [3:0]      cnt;
  logic [2:0]      pre_eff;
  logic [1:0]      mode_eff;
  logic [79:0]     hdr_init;
  logic [2:0]      pay_sym;

  always_comb begin
    if (pre_len < 3'd2)      pre_eff = 3'd2;
    else if (pre_len > 3'd5) pre_eff = 3'd5;
    else                     pre_eff = pre_len;
  end

  assign mode_eff = (mode == 2'd3) ? 2'd0 : mode;
  assign hdr_init = {40'hAAAAAAAAAA, UW, 6'd0, mode_eff};

  wire start_ok = start && (phase == ST_IDLE);
  wire tick     = (phase != ST_IDLE) && (div_cnt == DLAST);
  wire have     = cnt >= {2'b00, bps};
  assign in_ready = (phase != ST_IDLE) && (left != 9'd0) && !have;
  wire take     = in_valid && in_ready;
  wire hdr_emit = tick && (phase == ST_HDR);
  wire pay_emit = tick && (phase == ST_PAY) && (have || (left == 9'd0 && cnt != 4'd0));
  assign busy   = (phase != ST_IDLE);

  assign pay_sym = (bps == 2'd1) ? {2'b00, acc[10]} :
                   (bps == 2'd2) ? {1'b0, acc[10:9]} : acc[10:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      div_cnt  <= '0;
      hdr_sr   <= '0;
      hdr_left <= '0;
      bps      <= 2'd1;
      left     <= '0;
      acc      <= '0;
      cnt      <= '0;
      sym      <= '0;
      sym_stb  <= 1'b0;
    end else begin
      sym_stb <= 1'b0;
      if (start_ok) begin
        phase    <= ST_HDR;
        div_cnt  <= DIVW'(1);
        hdr_sr   <= hdr_init << (7'(3'd5 - pre_eff) * 7'd8);
        hdr_left <= 7'(pre_eff) * 7'd8 + 7'd40;
        bps      <= mode_eff + 2'd1;
        left     <= 9'(len_m1) + 9'd1;
        acc      <= '0;
        cnt      <= '0;
      end else if (phase != ST_IDLE) begin
        div_cnt <= tick ? '0 : div_cnt + DIVW'(1);
      end
      if (take) begin
        acc  <= acc | ({in_data, 3'b000} >> cnt);
        cnt  <= cnt + 4'd8;
        left <= left - 9'd1;
      end
      if (hdr_emit) begin
        sym      <= {2'b00, hdr_sr[79]};
        sym_stb  <= 1'b1;
        hdr_sr   <= hdr_sr << 1;
        hdr_left <= hdr_left - 7'd1;
        if (hdr_left == 7'd1) phase <= ST_PAY;
      end
      if (pay_emit) begin
        sym     <= pay_sym;
        sym_stb <= 1'b1;
        acc     <= acc << bps;
        cnt     <= have ? cnt - {2'b00, bps} : 4'd0;
        if (left == 9'd0 && cnt <= {2'b00, bps}) phase <= ST_IDLE;
      end
    end
  end

  logic [DIVW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap <= DLAST;
    else if (sym_stb)      gap <= '0;
    else if (gap != DLAST) gap <= gap + DIVW'(1);
  end

  p_hdr_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && $past(phase == ST_HDR)) |-> (sym[2:1] == 2'b00));

  p_pay_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> ((sym >> bps) == 3'd0));

  p_stb_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> (gap == DLAST));

  p_end_with_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sym_stb);

  p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(bps));
endmodule

// File: tb/test_psk_frame_tx.sv
module test_psk_frame_tx;
  localparam int DIV = 10;
  localparam logic [31:0] UW_EXP = 32'h9B58A3CD;
  localparam int NV = 11;
  // {pre_len[2:0], mode[1:0], len_m1[7:0], seed[7:0], stall, restart}
  localparam logic [22:0] VEC [NV] = '{
    {3'd2, 2'd0, 8'd0,   8'h5A, 1'b0, 1'b0},
    {3'd5, 2'd1, 8'd2,   8'hC3, 1'b0, 1'b0},
    {3'd3, 2'd2, 8'd0,   8'hFF, 1'b0, 1'b0},
    {3'd4, 2'd2, 8'd1,   8'h81, 1'b0, 1'b0},
    {3'd2, 2'd2, 8'd2,   8'h17, 1'b0, 1'b0},
    {3'd0, 2'd1, 8'd1,   8'h66, 1'b0, 1'b0},
    {3'd7, 2'd0, 8'd3,   8'h0F, 1'b0, 1'b0},
    {3'd3, 2'd3, 8'd1,   8'hE4, 1'b0, 1'b0},
    {3'd2, 2'd2, 8'd20,  8'h29, 1'b1, 1'b0},
    {3'd3, 2'd1, 8'd4,   8'h70, 1'b0, 1'b1},
    {3'd2, 2'd2, 8'd255, 8'h3C, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] pre_len = 3'd2;
  logic [1:0] mode = 2'd0;
  logic [7:0] len_m1 = 8'd0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, sym_stb, busy;
  logic [2:0] sym;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_sym [2200];
  int got_sym [2200];
  int got_c   [2200];

  always #5 clk = ~clk;

  psk_frame_tx i_psk_frame_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_len(pre_len), .mode(mode),
    .len_m1(len_m1), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sym_stb(sym_stb), .sym(sym), .busy(busy)
  );

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual cycle %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] pay_byte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29);
  endfunction

  task automatic run_frame(input logic [22:0] v);
    logic [2:0] pr = v[22:20];
    logic [1:0] md = v[19:18];
    logic [7:0] lm = v[17:10];
    logic [7:0] sd = v[9:2];
    bit stall = v[1];
    bit rhit = v[0];
    int ep = (pr < 2) ? 2 : (pr > 5) ? 5 : int'(pr);
    int em = (md == 2'd3) ? 0 : int'(md);
    int bpsv = em + 1;
    int n = int'(lm) + 1;
    int nb = n * 8;
    int hl = ep * 8 + 40;
    int k = 0;
    int ng = 0, idx = 0, c = 0, c_low = -1, bad, first_bad;
    bit take = 0, seen = 0, big_gap = 0;
    for (int b = 0; b < ep; b++)
      for (int i = 7; i >= 0; i--) exp_sym[k++] = (8'hAA >> i) & 1;
    for (int i = 31; i >= 0; i--) exp_sym[k++] = UW_EXP[i];
    for (int i = 7; i >= 0; i--) exp_sym[k++] = (em >> i) & 1;
    for (int s = 0; s < nb; s += bpsv) begin
      int val = 0;
      for (int j = 0; j < bpsv; j++) begin
        int p = s + j;
        int bit_v = (p < nb) ? ((pay_byte(sd, p / 8) >> (7 - p % 8)) & 1) : 0;
        val = val * 2 + bit_v;
      end
      exp_sym[k++] = val;
    end
    @(negedge clk);
    start = 1'b1; pre_len = pr; mode = md; len_m1 = lm;
    in_valid = 1'b1; in_data = pay_byte(sd, 0);
    forever begin
      @(negedge clk);
      c++;
      start = rhit && (c == 50);
      if (c == 50) begin pre_len = 3'd5; mode = 2'd2; len_m1 = 8'd7; end
      if (take) idx++;
      if (sym_stb) begin got_sym[ng] = int'(sym); got_c[ng] = c; ng++; end
      if (busy) seen = 1;
      else if (seen) begin c_low = c; break; end
      if (c > 20000) break;
      in_valid = !(stall && c >= 600 && c < 700) && (idx < n);
      in_data = (idx < n) ? pay_byte(sd, idx) : 8'd0;
      take = in_valid && in_ready;
    end
    in_valid = 1'b0;
    // header and preamble length
    bad = 0; first_bad = -1;
    for (int i = 0; i < hl - 8 && i < ng; i++)
      if (got_sym[i] != exp_sym[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (pr < 2 || pr > 5)
      check(bad == 0, "R3 clamped preamble/sync bits", first_bad < 0 ? 0 : got_sym[first_bad], first_bad < 0 ? 0 : exp_sym[first_bad]);
    else
      check(bad == 0, "R2 preamble/sync bits", first_bad < 0 ? 0 : got_sym[first_bad], first_bad < 0 ? 0 : exp_sym[first_bad]);
    // mode byte
    bad = 0; first_bad = -1;
    for (int i = hl - 8; i < hl && i < ng; i++)
      if (got_sym[i] != exp_sym[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    check(bad == 0, "R4 mode byte", first_bad < 0 ? 0 : got_sym[first_bad], first_bad < 0 ? 0 : exp_sym[first_bad]);
    // payload symbols
    bad = 0; first_bad = -1;
    for (int i = hl; i < k && i < ng; i++)
      if (got_sym[i] != exp_sym[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (bpsv == 3 && (nb % 3) != 0)
      check(bad == 0, "R6 padded 8-phase payload", first_bad < 0 ? 0 : got_sym[first_bad], first_bad < 0 ? 0 : exp_sym[first_bad]);
    else
      check(bad == 0, "R5 payload packing", first_bad < 0 ? 0 : got_sym[first_bad], first_bad < 0 ? 0 : exp_sym[first_bad]);
    check(ng == k, "R7 symbol count", ng, k);
    check(idx == n, "R7 bytes taken", idx, n);
    check(ng > 0 && got_c[0] == DIV, "R8 first strobe cycle", ng > 0 ? got_c[0] : -1, DIV);
    bad = 0;
    for (int i = 1; i < ng; i++) begin
      int d = got_c[i] - got_c[i-1];
      if (d > DIV) big_gap = 1;
      if (stall ? (d % DIV != 0) : (d != DIV)) bad++;
    end
    if (stall) begin
      check(bad == 0, "R9 spacing multiple of DIV", bad, 0);
      check(big_gap, "R9 skipped slot on underrun", int'(big_gap), 1);
    end else
      check(bad == 0, "R8 strobe spacing", bad, 0);
    check(ng > 0 && c_low == got_c[ng-1], "R10 busy falls with last strobe", c_low, ng > 0 ? got_c[ng-1] : -1);
    if (rhit) begin
      int extra = 0;
      repeat (40) begin @(negedge clk); if (busy || sym_stb) extra++; end
      check(extra == 0, "R11 start while busy not queued", extra, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !sym_stb && !in_ready, "R1 state in reset", int'({busy, sym_stb, in_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !sym_stb && !in_ready, "R1 state after reset", int'({busy, sym_stb, in_ready}), 0);
    for (int t = 0; t < NV; t++) begin
      run_frame(VEC[t]);
      repeat (5) @(negedge clk);
    end
    summary();
    $finish;
  end
endmodule